// File: doc/BRIEF.md
# Single-Step Shift/Rotate Unit

A purely combinational datapath element that moves a data word by at most one bit position. A 3-bit function code selects one of three actions. The word can pass through untouched. It can be shifted logically one place left or right, with the vacated bit taken from an external serial fill input. It can also be rotated one place left or right, with the bit that leaves one end re-entering at the other.

Each output bit is produced by its own 4-way selector. The selector picks among the bit in the same position, the bit one place lower, the bit one place higher, and a fill bit. A small decoder turns the function code into an operation class, and each bit slice turns that class into its selector setting. Only the end slices ever pick the fill bit. The block is placed between a register file and an accumulator to do single-step shifts and rotates in one pass.

Function code encoding: bit 2 set means move; with bit 2 set, bit 1 gives the direction (0 toward the MSB, 1 toward the LSB) and bit 0 chooses rotate (1) over logical shift (0).

Top module: `shrot_unit`

## Requirements
- R1: Function codes 000 and 001 drive data_o equal to data_i; bit 0 of the code has no effect.
- R2: The unassigned codes 010 and 011 also drive data_o equal to data_i.
- R3: Code 100 shifts left by one: data_o[7:1] = data_i[6:0] and data_o[0] = fill_rgt_i.
- R4: Code 101 rotates left by one: data_o[7:1] = data_i[6:0] and data_o[0] = data_i[7].
- R5: Code 110 shifts right by one: data_o[6:0] = data_i[7:1] and data_o[7] = fill_lft_i.
- R6: Code 111 rotates right by one: data_o[6:0] = data_i[7:1] and data_o[7] = data_i[0].
- R7: The fill inputs have no effect on data_o under pass and rotate codes (000, 001, 010, 011, 101, 111). fill_lft_i has no effect under a left shift, and fill_rgt_i has no effect under a right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 8 | Data word to be moved |
| func_i | input | 3 | Function code |
| fill_lft_i | input | 1 | Bit entering the MSB on a right shift |
| fill_rgt_i | input | 1 | Bit entering the LSB on a left shift |
| data_o | output | 8 | Result word |

## Verification
Each of the eight codes is applied to all-zero and all-one words, to single set bits at either end, and to the alternating patterns 0xA5 and 0x5A, under all four fill combinations. A single MSB or LSB bit shows whether an edge bit is dropped, wrapped or replaced by fill. The alternating patterns expose a neighbour taken from the wrong side. All-zero and all-one words under a shift show which fill input reached which end. A final sweep repeats pass and rotate codes with the fill bits toggled, so that any leakage of the fill bits shows up in the output.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_SHL  = 3'd1,
    OP_ROL  = 3'd2,
    OP_SHR  = 3'd3,
    OP_ROR  = 3'd4
  } op_t;

  typedef enum logic [1:0] {
    SEL_OWN  = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_FILL = 2'd3
  } sel_t;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output op_t               op_o
);
  always_comb begin
    unique casez (func_i)
      3'b0??:  op_o = OP_PASS;  // reserved codes alias to pass
      3'b100:  op_o = OP_SHL;
      3'b101:  op_o = OP_ROL;
      3'b110:  op_o = OP_SHR;
      default: op_o = OP_ROR;
    endcase
  end

  always_comb begin
    if (!func_i[2]) assert (op_o == OP_PASS) else $error("p_reserved_pass_r2");
  end
endmodule

// File: rtl/shrot_mux4.sv
module shrot_mux4
  import shrot_pkg::*;
(
  input  sel_t sel_i,
  input  logic own_i,
  input  logic lo_i,
  input  logic hi_i,
  input  logic fill_i,
  output logic y_o
);
  always_comb begin
    unique case (sel_i)
      SEL_OWN: y_o = own_i;
      SEL_LO:  y_o = lo_i;
      SEL_HI:  y_o = hi_i;
      default: y_o = fill_i;
    endcase
  end
endmodule

// File: rtl/shrot_slice.sv
module shrot_slice
  import shrot_pkg::*;
#(
  parameter bit IS_LSB = 1'b0,
  parameter bit IS_MSB = 1'b0
) (
  input  op_t  op_i,
  input  logic own_i,
  input  logic lo_i,    // lower neighbour, wraps to MSB at bit 0
  input  logic hi_i,    // upper neighbour, wraps to LSB at top bit
  input  logic fill_i,
  output logic y_o
);
  sel_t sel;

  always_comb begin
    unique case (op_i)
      OP_SHL:  sel = IS_LSB ? SEL_FILL : SEL_LO;
      OP_ROL:  sel = SEL_LO;
      OP_SHR:  sel = IS_MSB ? SEL_FILL : SEL_HI;
      OP_ROR:  sel = SEL_HI;
      default: sel = SEL_OWN;
    endcase
  end

  shrot_mux4 u_mux (
    .sel_i  (sel),
    .own_i  (own_i),
    .lo_i   (lo_i),
    .hi_i   (hi_i),
    .fill_i (fill_i),
    .y_o    (y_o)
  );

  always_comb begin
    if (!IS_LSB && !IS_MSB) assert (sel != SEL_FILL) else $error("p_inner_no_fill_r7");
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  data_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic              fill_lft_i,
  input  logic              fill_rgt_i,
  output logic [WIDTH-1:0]  data_o
);
  localparam int MSB = WIDTH - 1;

  op_t op;

  shrot_ctrl u_ctrl (
    .func_i (func_i),
    .op_o   (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int LO_IDX = (i == 0)   ? MSB : i - 1;
    localparam int HI_IDX = (i == MSB) ? 0   : i + 1;
    logic fill;
    if (i == 0) begin : g_lsb
      assign fill = fill_rgt_i;
    end else if (i == MSB) begin : g_msb
      assign fill = fill_lft_i;
    end else begin : g_mid
      assign fill = 1'b0;
    end

    shrot_slice #(
      .IS_LSB (i == 0),
      .IS_MSB (i == MSB)
    ) u_slice (
      .op_i   (op),
      .own_i  (data_i[i]),
      .lo_i   (data_i[LO_IDX]),
      .hi_i   (data_i[HI_IDX]),
      .fill_i (fill),
      .y_o    (data_o[i])
    );
  end

  always_comb begin
    // R1 and R2
    if (!func_i[2]) assert (data_o == data_i) else $error("p_pass_r1");
    if (func_i == 3'b100)
      assert (data_o[MSB:1] == data_i[MSB-1:0] && data_o[0] == fill_rgt_i)
        else $error("p_shl_r3");
    if (func_i == 3'b110)
      assert (data_o[MSB-1:0] == data_i[MSB:1] && data_o[MSB] == fill_lft_i)
        else $error("p_shr_r5");
    // R4 and R6: a rotate keeps the number of ones
    if (func_i[2] && func_i[0])
      assert ($countones(data_o) == $countones(data_i)) else $error("p_rot_ones_r4");
    if (func_i == 3'b111)
      assert (data_o[MSB] == data_i[0]) else $error("p_ror_wrap_r6");
  end
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic [2:0] func_i = '0;
  logic       fill_lft_i = 1'b0;
  logic       fill_rgt_i = 1'b0;
  logic [7:0] data_o;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shrot_unit dut (
    .data_i     (data_i),
    .func_i     (func_i),
    .fill_lft_i (fill_lft_i),
    .fill_rgt_i (fill_rgt_i),
    .data_o     (data_o)
  );

  function automatic logic [7:0] model(logic [7:0] d, logic [2:0] f, logic fl, logic fr);
    case (f)
      3'b100:  return {d[6:0], fr};
      3'b101:  return {d[6:0], d[7]};
      3'b110:  return {fl, d[7:1]};
      3'b111:  return {d[0], d[7:1]};
      default: return d;
    endcase
  endfunction

  function automatic string code_tag(logic [2:0] f);
    case (f)
      3'b000, 3'b001: return "R1";
      3'b010, 3'b011: return "R2";
      3'b100:         return "R3";
      3'b101:         return "R4";
      3'b110:         return "R5";
      default:        return "R6";
    endcase
  endfunction

  task automatic drive(logic [7:0] d, logic [2:0] f, logic fl, logic fr, string tag);
    item_t it;
    @(posedge clk);
    #1;
    data_i = d; func_i = f; fill_lft_i = fl; fill_rgt_i = fr;
    it.exp = model(d, f, fl, fr);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (data_o !== it.exp) begin
        n_bad++;
        $display("FAIL %s: func=%b d=%h fl=%b fr=%b got %h exp %h",
                 it.tag, func_i, data_i, fill_lft_i, fill_rgt_i, data_o, it.exp);
      end
    end
  end

  initial begin
    logic [7:0] pats[6];
    pats = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A};
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-time state: zero word, code 000 (R1)
    drive(8'h00, 3'b000, 1'b0, 1'b0, "R1");
    for (int p = 0; p < 6; p++)
      for (int f = 0; f < 8; f++)
        for (int fb = 0; fb < 4; fb++)
          drive(pats[p], 3'(f), fb[1], fb[0], code_tag(3'(f)));
    // R1: bit 0 of the code ignored while bit 2 clear
    drive(8'h3C, 3'b001, 1'b1, 1'b1, "R1");
    // R2: reserved codes leave word intact
    drive(8'hC3, 3'b010, 1'b1, 1'b0, "R2");
    drive(8'h96, 3'b011, 1'b0, 1'b1, "R2");
    // R3/R5 edge fill only
    drive(8'hFF, 3'b100, 1'b1, 1'b0, "R3");
    drive(8'h00, 3'b110, 1'b1, 1'b0, "R5");
    // R4/R6 wrap
    drive(8'h81, 3'b101, 1'b0, 1'b0, "R4");
    drive(8'h81, 3'b111, 1'b1, 1'b1, "R6");
    // R7: fill bits toggled where they must not matter
    for (int f = 0; f < 8; f++) begin
      if (f == 4 || f == 6) continue;
      for (int fb = 0; fb < 4; fb++)
        drive(8'h6B, 3'(f), fb[1], fb[0], "R7");
    end
    for (int fb = 0; fb < 2; fb++) begin
      drive(8'h6B, 3'b100, fb[0], 1'b1, "R7");
      drive(8'hD6, 3'b110, 1'b0, fb[0], "R7");
    end
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule